// File: doc/BRIEF.md
# Half-Duplex Reader Frame Sequencer

This block is the control state machine of a contactless reader that talks and listens on one channel, one direction at a time. A start command begins a transmit frame: a start-of-frame pattern, then the bytes the transmit buffer offers, then optional CRC bits, then an end-of-frame pattern. The transmitter then hands over to the receiver through two turnaround steps and a counted guard period. After that the block waits for carrier activity and follows the reception until it is reported complete or timed out. Bit coding, CRC arithmetic and the analog path belong to neighbouring blocks. This block only decides which phase is running and when each phase ends. All phase changes except the one-cycle turnaround steps advance on a bit-clock tick.

Software sees the block through one read-only status byte. That byte holds a 3-bit phase code, an interrupt line, a sticky error flag and two buffer-level flags. The phase code is fixed, because drivers decode it directly.

Top module: `rf_frame_seq`

## Requirements
- R1: While reset is asserted, with buffer level 0 and interrupt enables 0, the status byte reads 8'h05.
- R2: Status layout: bit 7 is always 0, bits 6:4 are the phase code, bit 3 is IRq, bit 2 is Err, bit 1 is HiAlert and bit 0 is LoAlert. The phase codes are 000 idle, 001 SOF, 010 data, 011 EOF, 100 turnaround, 101 receive-wait, 110 await, 111 receiving.
- R3: A start command in idle moves to SOF on the next cycle and clears Err. A start command in any other phase has no effect.
- R4: SOF ends on a tick. It goes to data if a byte is available and otherwise straight to EOF, with no data phase and no CRC.
- R5: In data, each tick with a byte available pulses tx_take_o in that cycle. The first tick with no byte goes to EOF, or, with CRC enabled, spends one further tick in data (code 010) with no take pulse and then goes to EOF.
- R6: EOF ends on a tick. The two turnaround steps that follow each last exactly one cycle and both show code 100. Receive-wait comes next.
- R7: Receive-wait loads the wait count when it is entered. It counts down one per tick and moves to await one cycle after reaching zero. A count of 0 spends a single cycle in receive-wait.
- R8: In await, receive activity moves the block to receiving on the next cycle.
- R9: In receiving, receive-done returns the block to idle and sets the done interrupt source (enable bit 0).
- R10: A receive timeout in await or receiving returns the block to idle. It sets Err and the error interrupt source (enable bit 1), and wins over activity and done in the same cycle.
- R11: IRq is 1 exactly when a pending source has its enable bit set. irq_clr_i clears both sources, but a source set in the same cycle stays set.
- R12: HiAlert is 1 when the buffer level is 56 or more. LoAlert is 1 when the level is 8 or less.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Start command |
| tx_avail_i | input | 1 | Transmit buffer holds a byte |
| tx_take_o | output | 1 | Byte consumed this cycle |
| crc_en_i | input | 1 | Append CRC bits after data |
| rxwait_i | input | WAIT_W | Receive-wait tick count |
| bit_tick_i | input | 1 | Bit-clock tick |
| rx_active_i | input | 1 | Carrier activity detected |
| rx_done_i | input | 1 | Reception complete |
| rx_timeout_i | input | 1 | Reception timed out |
| fifo_level_i | input | LVL_W | Current buffer fill level |
| irq_en_i | input | 2 | Interrupt enables {error, done} |
| irq_clr_i | input | 1 | Clear pending interrupt sources |
| status_o | output | 8 | Status byte |

## Verification
The assertions assume that the inputs change only between clock edges. They also assume that buffer-available and tick are meaningful in every cycle, with no handshake beyond the take pulse. The bench drives all inputs at the falling edge from a fixed-seed random source. Its buffer model raises tx_avail_i only while it still holds bytes, so take pulses never arrive when the buffer is empty. Directed phases hold tick, activity and done high so that the exact phase lengths are checked at zero and nonzero wait counts.

// File: rtl/rf_frame_seq.sv
module rf_frame_seq #(
  parameter int WAIT_W   = 16,
  parameter int LVL_W    = 7,
  parameter int HI_LEVEL = 56,
  parameter int LO_LEVEL = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              tx_avail_i,
  output logic              tx_take_o,
  input  logic              crc_en_i,
  input  logic [WAIT_W-1:0] rxwait_i,
  input  logic              bit_tick_i,
  input  logic              rx_active_i,
  input  logic              rx_done_i,
  input  logic              rx_timeout_i,
  input  logic [LVL_W-1:0]  fifo_level_i,
  input  logic [1:0]        irq_en_i,
  input  logic              irq_clr_i,
  output logic [7:0]        status_o
);
  typedef enum logic [3:0] {
    S_IDLE, S_SOF, S_DATA, S_EOF, S_TURN1, S_TURN2, S_WAIT, S_AWAIT, S_RECV
  } st_t;

  st_t st;
  logic [WAIT_W-1:0] cnt;
  logic crc_ph, err;
  logic [1:0] pend, pend_set;
  logic [2:0] code;

  wire rx_phase = (st == S_AWAIT) || (st == S_RECV);
  wire to_hit   = rx_phase && rx_timeout_i;
  wire done_hit = (st == S_RECV) && rx_done_i && !rx_timeout_i;

  assign tx_take_o = (st == S_DATA) && bit_tick_i && tx_avail_i && !crc_ph;
  assign pend_set  = {to_hit, done_hit};

  always_comb begin
    case (st)
      S_IDLE:          code = 3'b000;
      S_SOF:           code = 3'b001;
      S_DATA:          code = 3'b010;
      S_EOF:           code = 3'b011;
      S_TURN1, S_TURN2: code = 3'b100;
      S_WAIT:          code = 3'b101;
      S_AWAIT:         code = 3'b110;
      default:         code = 3'b111;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      crc_ph <= 1'b0;
      err    <= 1'b1;
      pend   <= 2'b00;
    end else begin
      pend <= (irq_clr_i ? 2'b00 : pend) | pend_set;
      if (to_hit) err <= 1'b1;
      case (st)
        S_IDLE: if (start_i) begin
          st  <= S_SOF;
          err <= 1'b0;
        end
        S_SOF: if (bit_tick_i) begin
          st     <= tx_avail_i ? S_DATA : S_EOF;
          crc_ph <= 1'b0;
        end
        S_DATA: if (bit_tick_i) begin
          if (crc_ph)                      st <= S_EOF;
          else if (!tx_avail_i && crc_en_i) crc_ph <= 1'b1;
          else if (!tx_avail_i)            st <= S_EOF;
        end
        S_EOF:   if (bit_tick_i) st <= S_TURN1;
        S_TURN1: st <= S_TURN2;
        S_TURN2: begin
          st  <= S_WAIT;
          cnt <= rxwait_i;
        end
        S_WAIT: begin
          if (cnt == '0)      st  <= S_AWAIT;
          else if (bit_tick_i) cnt <= cnt - 1'b1;
        end
        S_AWAIT: begin
          if (rx_timeout_i)     st <= S_IDLE;
          else if (rx_active_i) st <= S_RECV;
        end
        S_RECV: if (rx_timeout_i || rx_done_i) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign status_o = {1'b0, code, |(pend & irq_en_i), err,
                     fifo_level_i >= LVL_W'(HI_LEVEL),
                     fifo_level_i <= LVL_W'(LO_LEVEL)};
endmodule

// File: rtl/rf_frame_seq_chk.sv
module rf_frame_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       bit_tick_i,
  input logic       rx_active_i,
  input logic       rx_done_i,
  input logic       rx_timeout_i,
  input logic [1:0] irq_en_i,
  input logic       tx_take_o,
  input logic [7:0] status_o
);
  wire [2:0] code = status_o[6:4];

  p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (code == 3'b000 && start_i) |=> (code == 3'b001 && !status_o[2]));

  p_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take_o |-> (code == 3'b010 && bit_tick_i));

  p_eof_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (code == 3'b011 && bit_tick_i) |=> code == 3'b100);

  p_turn_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (code == 3'b100 && $past(code) == 3'b100) |=> code == 3'b101);

  p_recv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (code == 3'b110 && rx_active_i && !rx_timeout_i) |=> code == 3'b111);

  p_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (code == 3'b111 && rx_done_i) |=> code == 3'b000);

  p_timeout_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (code[2:1] == 2'b11 && rx_timeout_i) |=> (code == 3'b000 && status_o[2]));

  p_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en_i == 2'b00) |-> !status_o[3]);
endmodule

bind rf_frame_seq rf_frame_seq_chk u_chk (.*);

// File: tb/rf_frame_seq_bench.sv
module rf_frame_seq_bench;
  logic clk = 0, rst_n = 0;
  logic start_i = 0, tx_avail_i = 0, crc_en_i = 0, bit_tick_i = 0;
  logic rx_active_i = 0, rx_done_i = 0, rx_timeout_i = 0, irq_clr_i = 0;
  logic [15:0] rxwait_i = 0;
  logic [6:0]  fifo_level_i = 0;
  logic [1:0]  irq_en_i = 0;
  logic        tx_take_o;
  logic [7:0]  status_o;

  rf_frame_seq u_rf_frame_seq (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;

  int m_st = 0, m_cnt = 0, bcnt = 0;
  bit m_crcph = 0, m_err = 1;
  bit [1:0] m_pend = 0;

  int p_start, p_tick, p_act, p_done, p_to, p_clr, k_bytes, k_wait, k_crc;

  function automatic bit [2:0] code_of(int s);
    case (s)
      0: return 3'd0; 1: return 3'd1; 2: return 3'd2; 3: return 3'd3;
      4, 5: return 3'd4; 6: return 3'd5; 7: return 3'd6; default: return 3'd7;
    endcase
  endfunction

  function automatic string tag_of(int s);
    case (s)
      0: return "R3"; 1: return "R4"; 2: return "R5"; 3, 4, 5: return "R6";
      6: return "R7"; 7: return "R8"; default: return "R9";
    endcase
  endfunction

  function automatic bit [7:0] exp_status();
    return {1'b0, code_of(m_st), |(m_pend & irq_en_i), m_err,
            fifo_level_i >= 7'd56, fifo_level_i <= 7'd8};
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    bit [7:0] e;
    string t;
    bit exp_take;
    bit [1:0] sets;
    @(negedge clk);
    e = exp_status();
    if (status_o[6:4] !== e[6:4]) t = tag_of(m_st);
    else if (status_o[7] !== e[7]) t = "R2";
    else if (status_o[3] !== e[3]) t = "R11";
    else if (status_o[2] !== e[2]) t = "R10";
    else t = "R12";
    check(t, status_o, e);
    if (m_st == 0 && ($urandom % 100) < p_start) begin
      start_i = 1;
      bcnt = (k_bytes < 0) ? int'($urandom % 5) : k_bytes;
      rxwait_i = 16'((k_wait < 0) ? ($urandom % 5) : k_wait);
      crc_en_i = (k_crc < 0) ? 1'($urandom) : 1'(k_crc);
    end else start_i = (($urandom % 100) < 3);
    bit_tick_i   = (($urandom % 100) < p_tick);
    rx_active_i  = (($urandom % 100) < p_act);
    rx_done_i    = (($urandom % 100) < p_done);
    rx_timeout_i = (($urandom % 100) < p_to);
    irq_clr_i    = (($urandom % 100) < p_clr);
    irq_en_i     = 2'($urandom);
    fifo_level_i = 7'($urandom);
    tx_avail_i   = (bcnt > 0);
    #1;
    exp_take = (m_st == 2) && bit_tick_i && (bcnt > 0) && !m_crcph;
    check("R5 take", {7'd0, tx_take_o}, {7'd0, exp_take});
    sets = 0;
    case (m_st)
      0: if (start_i) begin m_st = 1; m_err = 0; end
      1: if (bit_tick_i) begin m_st = (bcnt > 0) ? 2 : 3; m_crcph = 0; end
      2: if (bit_tick_i) begin
           if (m_crcph) m_st = 3;
           else if (bcnt > 0) bcnt--;
           else if (crc_en_i) m_crcph = 1;
           else m_st = 3;
         end
      3: if (bit_tick_i) m_st = 4;
      4: m_st = 5;
      5: begin m_st = 6; m_cnt = int'(rxwait_i); end
      6: if (m_cnt == 0) m_st = 7; else if (bit_tick_i) m_cnt--;
      7: if (rx_timeout_i) begin m_st = 0; m_err = 1; sets[1] = 1; end
         else if (rx_active_i) m_st = 8;
      default: if (rx_timeout_i) begin m_st = 0; m_err = 1; sets[1] = 1; end
         else if (rx_done_i) begin m_st = 0; sets[0] = 1; end
    endcase
    m_pend = (irq_clr_i ? 2'b00 : m_pend) | sets;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    #10;
    check("R1 reset", status_o, 8'h05);
    @(negedge clk);
    rst_n = 1;
    // R1 and R2 after release: idle, Err set, level 0
    #1;
    check("R2 layout", status_o, 8'h05);
    // directed: two bytes, CRC, wait 3, every tick
    p_start = 100; p_tick = 100; p_act = 100; p_done = 100; p_to = 0; p_clr = 0;
    k_bytes = 2; k_wait = 3; k_crc = 1;
    run(40);
    // directed: empty buffer, wait 0 (R4, R7)
    k_bytes = 0; k_wait = 0; k_crc = 0;
    run(30);
    // directed: timeout in await (R10)
    p_act = 0; p_to = 50; k_bytes = 1;
    run(60);
    // random
    p_start = 20; p_tick = 50; p_act = 20; p_done = 15; p_to = 4; p_clr = 6;
    k_bytes = -1; k_wait = -1; k_crc = -1;
    run(6000);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    finish_run();
  end
endmodule